// File: doc/BRIEF.md
# Timer Channel Compare and Capture Controller

This block drives one channel of a general-purpose timer. The counter lives outside the block; the block sees the counter value every cycle, together with the update event, a trigger input and three possible capture sources. In output mode it compares the counter against its compare register and drives a channel output level. The output can be frozen, toggled on a match, or produced as PWM in either polarity. In input mode it watches a selected source and, on a rising edge, stores the counter value in the same register and raises a one-cycle capture strobe.

Software sets the block up through two write strobes. The configuration write carries the channel mode, the output function, a shadow enable for the compare value, and a fast enable. The compare write carries a new compare value. With shadow enabled, a new compare value waits in a shadow register until the next update event. With fast enable set in a PWM function, a synchronised rising edge on the trigger input acts as an early compare match. The output then jumps to its after-match level three cycles after the trigger, instead of waiting for the counter to get there.

The control core is a five-state machine.

States:
- `ST_OFF`: the channel is disabled.
- `ST_CMP`: the output follows the comparison.
- `ST_FORCED`: the output is held at the after-match level by a fast trigger.
- `ST_ARMED`: the channel waits for a capture edge.
- `ST_CAPT`: the cycle holding the capture strobe.

Transitions:
- OFF→CMP or OFF→FORCED when the channel is enabled in output mode.
- OFF→ARMED or OFF→CAPT when it is enabled in an input mode.
- CMP→FORCED on a fast trigger hit.
- FORCED→CMP on an update event, or once the counter reaches the compare value.
- ARMED→CAPT on a valid rising edge.
- CAPT→CAPT on a further edge, otherwise CAPT→ARMED.
- Any state→OFF when the enable drops.

Top module: `tmr_ch_ctrl`

## Requirements
- R1: After reset: `ch_out`=0, `cap_stb`=0, `cc_val`=0. Mode is output (00), function is frozen, and shadow and fast enables are clear.
- R2: With shadow clear in output mode, a compare write shows on `cc_val` at the clock edge that accepts it.
- R3: With shadow set in output mode, a compare write leaves `cc_val` unchanged. The value moves to `cc_val` at the first edge where `upd_evt` is high.
- R4: In output mode with `ch_en`=1, `ch_out` is registered from the counter value of the previous cycle:
  - function 10 (PWM0): `ch_out` = counter < compare;
  - function 11 (PWM1): `ch_out` = counter >= compare;
  - `ch_en`=0 drives `ch_out` to 0 at the next edge.
- R5: Function 01 (toggle) inverts `ch_out` at each edge where counter equals compare. Function 00 (frozen) holds `ch_out`.
- R6: With fast set and function PWM0/PWM1, a rise on `trig_in` forces `ch_out` to the after-match level (1 for PWM1, 0 for PWM1's inverse PWM0) 3 clock edges after the rise. The forced level holds until an update event or until counter >= compare.
- R7: With fast clear, a `trig_in` edge has no effect on `ch_out`.
- R8: In an input mode with `ch_en`=1, a rising edge on the selected source copies the counter into `cc_val` and pulses `cap_stb` for exactly one cycle, at the same edge. Source selection by mode:
  - 01 → `cap_own`;
  - 10 → `cap_nbr`;
  - 11 → `itrig`.
- R9: In mode 11 with `itrig_sel`=0, no capture occurs.
- R10: A configuration write while `ch_en`=1 leaves the mode unchanged but updates the function, shadow and fast fields. A write while `ch_en`=0 updates the mode as well.
- R11: In any input mode, `ch_out` stays 0 and compare writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 1 | Channel enable |
| cnt_val | input | CNT_W | Shared counter value |
| upd_evt | input | 1 | Update event pulse |
| trig_in | input | 1 | Trigger input (asynchronous, synchronised inside) |
| cap_own | input | 1 | This channel's filtered capture input |
| cap_nbr | input | 1 | Neighbouring channel's filtered capture input |
| itrig | input | 1 | Internal trigger |
| itrig_sel | input | 1 | High when the slave configuration selects an internal trigger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Channel mode: 00 output, 01 own, 10 neighbour, 11 internal trigger |
| cfg_fn | input | 2 | Output function: 00 frozen, 01 toggle, 10 PWM0, 11 PWM1 |
| cfg_shadow | input | 1 | Compare shadow enable |
| cfg_fast | input | 1 | Fast trigger enable |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| ch_out | output | 1 | Channel output level |
| cap_stb | output | 1 | One-cycle capture strobe |
| cc_val | output | CNT_W | Active compare/capture register |

## Verification
A wrong state in the machine shows on `ch_out` at the very next edge. A channel stuck in FORCED keeps the after-match level after the counter passes the compare value. A channel stuck in CAPT produces a second `cap_stb` cycle. A corrupted compare or shadow register shows on `cc_val` at once, or at the next update event, and then on `ch_out` in the first cycle whose counter falls between the right and wrong compare values. The trigger pipeline is only visible through the fast path, so its depth is checked by counting the exact edge at which the forced level appears.

// File: rtl/tmr_ch_pkg.sv
package tmr_ch_pkg;

    typedef enum logic [1:0] {
        SRC_OUT = 2'b00,
        SRC_OWN = 2'b01,
        SRC_NBR = 2'b10,
        SRC_ITR = 2'b11
    } ch_mode_e;

    typedef enum logic [1:0] {
        OC_FROZEN = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_PWM0   = 2'b10,
        OC_PWM1   = 2'b11
    } oc_fn_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMP,
        ST_FORCED,
        ST_ARMED,
        ST_CAPT
    } ch_state_e;

    typedef struct packed {
        ch_mode_e mode;
        oc_fn_e   fn;
        logic     shadow;
        logic     fast;
    } ch_cfg_t;

endpackage

// File: rtl/tmr_ch_cfg.sv
module tmr_ch_cfg
    import tmr_ch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ch_en,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_fn,
    input  logic       cfg_shadow,
    input  logic       cfg_fast,
    output ch_cfg_t    cfg_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mode   <= SRC_OUT;
            cfg_q.fn     <= OC_FROZEN;
            cfg_q.shadow <= 1'b0;
            cfg_q.fast   <= 1'b0;
        end else if (cfg_we) begin
            cfg_q.fn     <= oc_fn_e'(cfg_fn);
            cfg_q.shadow <= cfg_shadow;
            cfg_q.fast   <= cfg_fast;
            // the mode field is locked while the channel runs
            if (!ch_en) begin
                cfg_q.mode <= ch_mode_e'(cfg_mode);
            end
        end
    end

endmodule

// File: rtl/tmr_ch_trig.sv
module tmr_ch_trig #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);

    localparam int SW = STAGES + 1;

    logic sq [SW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq[0] <= 1'b0;
        end else begin
            sq[0] <= trig_in;
        end
    end

    for (genvar i = 1; i < SW; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sq[i] <= 1'b0;
            end else begin
                sq[i] <= sq[i-1];
            end
        end
    end

    assign trig_rise = sq[SW-2] & ~sq[SW-1];

endmodule

// File: rtl/tmr_ch_insel.sv
module tmr_ch_insel
    import tmr_ch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ch_mode_e mode,
    input  logic     itrig_sel,
    input  logic     cap_own,
    input  logic     cap_nbr,
    input  logic     itrig,
    output logic     cap_rise
);

    logic own_q, nbr_q, itr_q;
    logic sel_now, sel_old, sel_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= 1'b0;
            nbr_q <= 1'b0;
            itr_q <= 1'b0;
        end else begin
            own_q <= cap_own;
            nbr_q <= cap_nbr;
            itr_q <= itrig;
        end
    end

    always_comb begin
        sel_now = 1'b0;
        sel_old = 1'b0;
        sel_ok  = 1'b1;
        unique case (mode)
            SRC_OUT: sel_ok = 1'b0;
            SRC_OWN: begin sel_now = cap_own; sel_old = own_q; end
            SRC_NBR: begin sel_now = cap_nbr; sel_old = nbr_q; end
            SRC_ITR: begin sel_now = itrig;   sel_old = itr_q; sel_ok = itrig_sel; end
        endcase
    end

    assign cap_rise = sel_ok & sel_now & ~sel_old;

endmodule

// File: rtl/tmr_ch_ccreg.sv
module tmr_ch_ccreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_mode,
    input  logic             shadow_en,
    input  logic             upd_evt,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cap_take,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cc_act
);

    logic [CNT_W-1:0] cc_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_act <= '0;
            cc_sh  <= '0;
        end else if (cap_take) begin
            cc_act <= cnt_val;
        end else if (out_mode) begin
            if (upd_evt && shadow_en) begin
                cc_act <= cc_sh;
            end
            if (cmp_we && !shadow_en) begin
                cc_act <= cmp_wdata;
            end
            if (cmp_we) begin
                cc_sh <= cmp_wdata;
            end
        end
    end

endmodule

// File: rtl/tmr_ch_fsm.sv
module tmr_ch_fsm
    import tmr_ch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  ch_cfg_t          cfg,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cc_act,
    input  logic             upd_evt,
    input  logic             trig_rise,
    input  logic             cap_rise,
    output logic             cap_take,
    output logic             ch_out,
    output logic             cap_stb
);

    ch_state_e state_q, state_d;
    logic      cnt_lt, cnt_eq, is_pwm, fast_hit;
    logic      out_d;

    assign cnt_lt   = cnt_val < cc_act;
    assign cnt_eq   = cnt_val == cc_act;
    assign is_pwm   = (cfg.fn == OC_PWM0) || (cfg.fn == OC_PWM1);
    assign fast_hit = trig_rise & cfg.fast & is_pwm;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg.mode == SRC_OUT) begin
                    state_d = fast_hit ? ST_FORCED : ST_CMP;
                end else begin
                    state_d = cap_rise ? ST_CAPT : ST_ARMED;
                end
            end
            ST_CMP:    if (fast_hit) state_d = ST_FORCED;
            ST_FORCED: if (upd_evt || !cnt_lt) state_d = ST_CMP;
            ST_ARMED,
            ST_CAPT:   state_d = cap_rise ? ST_CAPT : ST_ARMED;
            default:   state_d = ST_OFF;
        endcase
        if (!ch_en) begin
            state_d = ST_OFF;
        end
    end

    assign cap_take = (state_d == ST_CAPT);

    // outputs
    always_comb begin
        out_d = ch_out;
        unique case (state_d)
            ST_OFF, ST_ARMED, ST_CAPT: out_d = 1'b0;
            ST_FORCED:                 out_d = (cfg.fn == OC_PWM1);
            ST_CMP: begin
                unique case (cfg.fn)
                    OC_FROZEN: out_d = ch_out;
                    OC_TOGGLE: out_d = cnt_eq ? ~ch_out : ch_out;
                    OC_PWM0:   out_d = cnt_lt;
                    OC_PWM1:   out_d = ~cnt_lt;
                endcase
            end
            default: out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_out  <= 1'b0;
            cap_stb <= 1'b0;
        end else begin
            ch_out  <= out_d;
            cap_stb <= cap_take;
        end
    end

endmodule

// File: rtl/tmr_ch_ctrl.sv
module tmr_ch_ctrl
    import tmr_ch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TRIG_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             upd_evt,
    input  logic             trig_in,
    input  logic             cap_own,
    input  logic             cap_nbr,
    input  logic             itrig,
    input  logic             itrig_sel,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_fn,
    input  logic             cfg_shadow,
    input  logic             cfg_fast,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             ch_out,
    output logic             cap_stb,
    output logic [CNT_W-1:0] cc_val
);

    ch_cfg_t    cfg_q;
    logic [1:0] mode_q;
    logic       shadow_q;
    logic       trig_rise, cap_rise, cap_take;

    assign mode_q   = cfg_q.mode;
    assign shadow_q = cfg_q.shadow;

    tmr_ch_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_fn    (cfg_fn),
        .cfg_shadow(cfg_shadow),
        .cfg_fast  (cfg_fast),
        .cfg_q     (cfg_q)
    );

    tmr_ch_trig #(.STAGES(TRIG_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .trig_rise(trig_rise)
    );

    tmr_ch_insel u_insel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_q.mode),
        .itrig_sel(itrig_sel),
        .cap_own  (cap_own),
        .cap_nbr  (cap_nbr),
        .itrig    (itrig),
        .cap_rise (cap_rise)
    );

    tmr_ch_ccreg #(.CNT_W(CNT_W)) u_cc (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_mode (cfg_q.mode == SRC_OUT),
        .shadow_en(cfg_q.shadow),
        .upd_evt  (upd_evt),
        .cmp_we   (cmp_we),
        .cmp_wdata(cmp_wdata),
        .cap_take (cap_take),
        .cnt_val  (cnt_val),
        .cc_act   (cc_val)
    );

    tmr_ch_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_en    (ch_en),
        .cfg      (cfg_q),
        .cnt_val  (cnt_val),
        .cc_act   (cc_val),
        .upd_evt  (upd_evt),
        .trig_rise(trig_rise),
        .cap_rise (cap_rise),
        .cap_take (cap_take),
        .ch_out   (ch_out),
        .cap_stb  (cap_stb)
    );

endmodule

// File: rtl/tmr_ch_ctrl_chk.sv
module tmr_ch_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             upd_evt,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ch_out,
    input logic             cap_stb,
    input logic [CNT_W-1:0] cc_val,
    input logic [1:0]       mode_q,
    input logic             shadow_q
);

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q && !upd_evt && mode_q == 2'b00) |=> $stable(cc_val));

    p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> !ch_out);

    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !cap_stb);

    p_cap_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> cc_val == $past(cnt_val));

    p_mode_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |=> $stable(mode_q));

    p_in_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && mode_q != 2'b00) |=> !ch_out);

endmodule

bind tmr_ch_ctrl tmr_ch_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_en   (ch_en),
    .upd_evt (upd_evt),
    .cnt_val (cnt_val),
    .ch_out  (ch_out),
    .cap_stb (cap_stb),
    .cc_val  (cc_val),
    .mode_q  (mode_q),
    .shadow_q(shadow_q)
);

// File: tb/tmr_ch_ctrl_test.sv
module tmr_ch_ctrl_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ch_en = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         upd_evt = 1'b0;
    logic         trig_in = 1'b0;
    logic         cap_own = 1'b0;
    logic         cap_nbr = 1'b0;
    logic         itrig = 1'b0;
    logic         itrig_sel = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_mode = '0;
    logic [1:0]   cfg_fn = '0;
    logic         cfg_shadow = 1'b0;
    logic         cfg_fast = 1'b0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         ch_out, cap_stb;
    logic [W-1:0] cc_val;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tmr_ch_ctrl #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cnt_val(cnt_val),
        .upd_evt(upd_evt), .trig_in(trig_in), .cap_own(cap_own),
        .cap_nbr(cap_nbr), .itrig(itrig), .itrig_sel(itrig_sel),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_fn(cfg_fn),
        .cfg_shadow(cfg_shadow), .cfg_fast(cfg_fast), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .ch_out(ch_out), .cap_stb(cap_stb),
        .cc_val(cc_val)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, stepped on every rising edge
    logic         m_out, m_stb, m_forced;
    logic [W-1:0] m_act, m_sh, n_act, n_sh;
    int           m_mode, m_fn;
    logic         m_shen, m_fast;
    bit           tq[$];
    logic         p_own, p_nbr, p_itr;
    bit           te, lt, eq, src, psrc, valid, rise;
    bit           model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_stb = 0; m_forced = 0; m_act = '0; m_sh = '0;
            m_mode = 0; m_fn = 0; m_shen = 0; m_fast = 0;
            tq = '{0, 0, 0};
            p_own = 0; p_nbr = 0; p_itr = 0;
        end else begin
            te = tq[1] && !tq[2];
            lt = cnt_val < m_act;
            eq = cnt_val == m_act;
            case (m_mode)
                1: begin src = cap_own; psrc = p_own; end
                2: begin src = cap_nbr; psrc = p_nbr; end
                3: begin src = itrig;   psrc = p_itr; end
                default: begin src = 0; psrc = 0; end
            endcase
            valid = (m_mode != 3) || itrig_sel;
            rise  = (m_mode != 0) && valid && src && !psrc;
            n_act = m_act;
            n_sh  = m_sh;
            m_stb = 0;
            if (!ch_en) begin
                m_out = 0; m_forced = 0;
            end else if (m_mode == 0) begin
                if (m_forced) begin
                    if (upd_evt || !lt) m_forced = 0;
                end else if (te && m_fast && m_fn >= 2) begin
                    m_forced = 1;
                end
                if (m_forced) m_out = (m_fn == 3);
                else begin
                    case (m_fn)
                        1: if (eq) m_out = !m_out;
                        2: m_out = lt;
                        3: m_out = !lt;
                        default: ;
                    endcase
                end
            end else begin
                m_out = 0; m_forced = 0;
                if (rise) begin m_stb = 1; n_act = cnt_val; end
            end
            if (m_mode == 0) begin
                if (upd_evt && m_shen) n_act = m_sh;
                if (cmp_we && !m_shen) n_act = cmp_wdata;
                if (cmp_we) n_sh = cmp_wdata;
            end
            m_act = n_act;
            m_sh  = n_sh;
            if (cfg_we) begin
                m_fn = int'(cfg_fn); m_shen = cfg_shadow; m_fast = cfg_fast;
                if (!ch_en) m_mode = int'(cfg_mode);
            end
            tq.push_front(trig_in);
            void'(tq.pop_back());
            p_own = cap_own; p_nbr = cap_nbr; p_itr = itrig;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk(ch_out == m_out,   "MODEL ch_out R4 R5 R6 R7", ch_out, m_out);
            chk(cap_stb == m_stb,  "MODEL cap_stb R8 R9",      cap_stb, m_stb);
            chk(cc_val == m_act,   "MODEL cc_val R2 R3 R8",    cc_val, m_act);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input int md, input int fn, input bit sh, input bit fs);
        cfg_we = 1; cfg_mode = md[1:0]; cfg_fn = fn[1:0]; cfg_shadow = sh; cfg_fast = fs;
        tick(1);
        cfg_we = 0;
    endtask

    task automatic wr_cmp(input int v);
        cmp_we = 1; cmp_wdata = v[W-1:0];
        tick(1);
        cmp_we = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        int lat;
        logic hold;
        tick(3);
        rst_n = 1;
        model_on = 1;
        // R1 reset state
        chk(ch_out == 0,  "R1 ch_out after reset", ch_out, 0);
        chk(cap_stb == 0, "R1 cap_stb after reset", cap_stb, 0);
        chk(cc_val == 0,  "R1 cc_val after reset", cc_val, 0);
        tick(1);

        // R2 immediate compare write
        wr_cfg(0, 2, 0, 0);
        wr_cmp(10);
        chk(cc_val == 10, "R2 direct write", cc_val, 10);

        // R4 PWM0 and PWM1
        ch_en = 1;
        for (int i = 0; i < 16; i++) begin
            cnt_val = i[W-1:0];
            tick(1);
            chk(ch_out == (i < 10), "R4 pwm0 level", ch_out, (i < 10));
        end
        wr_cfg(0, 3, 0, 0);
        for (int i = 0; i < 16; i++) begin
            cnt_val = i[W-1:0];
            tick(1);
            chk(ch_out == (i >= 10), "R4 pwm1 level", ch_out, (i >= 10));
        end

        // R3 shadowed write
        wr_cfg(0, 3, 1, 0);
        wr_cmp(20);
        chk(cc_val == 10, "R3 shadow holds", cc_val, 10);
        tick(2);
        chk(cc_val == 10, "R3 shadow still holds", cc_val, 10);
        upd_evt = 1; tick(1); upd_evt = 0;
        chk(cc_val == 20, "R3 update copies shadow", cc_val, 20);

        // R5 toggle and frozen
        wr_cfg(0, 1, 1, 0);
        cnt_val = 5; tick(2);
        hold = ch_out;
        cnt_val = 20; tick(1);
        chk(ch_out == !hold, "R5 toggle on match", ch_out, !hold);
        cnt_val = 5; tick(2);
        chk(ch_out == !hold, "R5 no toggle off match", ch_out, !hold);
        wr_cfg(0, 0, 1, 0);
        hold = ch_out;
        for (int i = 0; i < 30; i += 3) begin
            cnt_val = i[W-1:0];
            tick(1);
            chk(ch_out == hold, "R5 frozen holds", ch_out, hold);
        end

        // R6 fast trigger, PWM1, compare 20, counter 0
        wr_cfg(0, 3, 0, 1);
        cnt_val = 0; tick(2);
        chk(ch_out == 0, "R6 pre-trigger level", ch_out, 0);
        trig_in = 1;
        lat = 0;
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            if (ch_out && lat == 0) lat = k;
        end
        chk(lat == 3, "R6 fast latency", lat, 3);
        chk(ch_out == 1, "R6 forced level held", ch_out, 1);
        trig_in = 0;
        upd_evt = 1; tick(1); upd_evt = 0;
        chk(ch_out == 0, "R6 update releases force", ch_out, 0);

        // R7 trigger without fast
        wr_cfg(0, 3, 0, 0);
        tick(1);
        trig_in = 1;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            chk(ch_out == 0, "R7 trigger ignored", ch_out, 0);
        end
        trig_in = 0;

        // R10 mode write while enabled is ignored, function taken
        wr_cfg(1, 2, 0, 0);
        tick(1);
        chk(ch_out == 1, "R10 fn applied, mode kept as output", ch_out, 1);

        // R8 own source capture, R10 mode taken while disabled
        ch_en = 0; tick(1);
        wr_cfg(1, 2, 0, 0);
        ch_en = 1; tick(1);
        cnt_val = 33; cap_own = 1; tick(1);
        chk(cap_stb == 1, "R8 own strobe", cap_stb, 1);
        chk(cc_val == 33, "R8 own captured", cc_val, 33);
        chk(ch_out == 0, "R11 output low in input mode", ch_out, 0);
        tick(1);
        chk(cap_stb == 0, "R8 strobe one cycle", cap_stb, 0);
        wr_cmp(7);
        chk(cc_val == 33, "R11 compare write ignored", cc_val, 33);
        cap_own = 0; tick(1);

        // R8 neighbour source
        ch_en = 0; tick(1);
        wr_cfg(2, 2, 0, 0);
        ch_en = 1; tick(1);
        cap_own = 1; tick(1);
        chk(cap_stb == 0, "R8 own ignored in neighbour mode", cap_stb, 0);
        cap_own = 0; cnt_val = 44; cap_nbr = 1; tick(1);
        chk(cap_stb == 1 && cc_val == 44, "R8 neighbour capture", cc_val, 44);
        cap_nbr = 0; tick(1);

        // R9 internal trigger without selection, then R8 with selection
        ch_en = 0; tick(1);
        wr_cfg(3, 2, 0, 0);
        ch_en = 1; tick(1);
        cnt_val = 50; itrig = 1;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk(cap_stb == 0 && cc_val == 44, "R9 no capture unselected", cc_val, 44);
        end
        itrig = 0; itrig_sel = 1; tick(1);
        cnt_val = 55; itrig = 1; tick(1);
        chk(cap_stb == 1 && cc_val == 55, "R8 internal trigger capture", cc_val, 55);
        itrig = 0; tick(1);

        // R4 disabled output low
        ch_en = 0; tick(1);
        wr_cfg(0, 3, 0, 0);
        wr_cmp(1);
        ch_en = 1; cnt_val = 60; tick(2);
        chk(ch_out == 1, "R4 pwm1 above compare", ch_out, 1);
        ch_en = 0; tick(1);
        chk(ch_out == 0, "R4 disabled low", ch_out, 0);
        tick(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule